// File: doc/BRIEF.md
# Bytewide RAM Access Controller with Power-Fail Lockout

This block sits between a parallel byte bus and a 2K x 8 storage array. The bus uses a chip enable, an output enable and a write enable, all active low. The block decodes them into deselect, read, write and output-disabled cases. The eight highest addresses do not reach the RAM. They are routed to a clock and control register port, which is served by a timekeeping block outside this one. The interface is modelled as synchronous logic: the pins are sampled on the clock, and the bus is driven through a data-enable output that an external tri-state buffer uses.

An external supply comparator asserts a power-fail input. From that moment the block ignores the bus. It keeps ignoring the bus for a recovery interval of `RECOV_CYCLES` clock cycles after the input is released. The interval restarts if power drops again before it has expired. Throughout the lockout the block pulls an open-drain status output low. At all other times it releases that output.

A write is held in capture registers while the strobe is active. It is committed only on the cycle the strobe ends. As a result, a write that is interrupted by a power failure is dropped, and the target byte keeps its old value.

Top module: `bytewide_ram_ctrl`

## Requirements
- R1: After reset, data_oe_o is 0, pf_pull_o is 0 and reg_wr_o is 0.
- R2: A cycle in which ce_ni is 1 drives nothing on the bus (data_oe_o 0 after the next edge) and writes nothing, whatever we_ni and oe_ni are.
- R3: With ce_ni 0, we_ni 1 and oe_ni 0 sampled at an edge, data_oe_o is 1 after that edge and data_o holds the byte stored at addr_i.
- R4: With ce_ni 0, we_ni 1 and oe_ni 1, data_oe_o stays 0.
- R5: With ce_ni 0 and we_ni 0, the cycle is a write whatever oe_ni is. The bus is not driven during the write. The byte is committed on the edge where the strobe is first seen ended, and the data sampled last while the strobe was active is the data committed.
- R6: Addresses 0x7F8 to 0x7FF select the register port and never the RAM. A committed write there raises reg_wr_o for exactly one cycle, with reg_wr_idx_o equal to address bits [2:0] and reg_wdata_o equal to the byte. A read there returns reg_rdata_i, and reg_rd_idx_o follows addr_i[2:0]. Address 0x7F7 is the last RAM byte.
- R7: pf_pull_o is 1 in the same cycle that pwr_fail_i is 1. After pwr_fail_i is released, pf_pull_o stays 1 through RECOV_CYCLES clock edges and is 0 after the RECOV_CYCLES-th edge.
- R8: For as long as pf_pull_o is 1, reads are not driven and writes are not committed. This covers the whole recovery interval, not only the time pwr_fail_i is high.
- R9: A write whose strobe is active when power fails is dropped, and the addressed byte keeps its previous value.
- R10: If pwr_fail_i is asserted again during recovery, the interval restarts in full from its next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 11 | Byte address |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data to the bus |
| data_oe_o | output | 1 | Bus drive enable for the external tri-state buffer |
| pwr_fail_i | input | 1 | Supply below threshold, from the external comparator |
| pf_pull_o | output | 1 | 1 = pull the open-drain power-fail line low |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wr_idx_o | output | 3 | Register index of the write |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_idx_o | output | 3 | Register index currently addressed |
| reg_rdata_i | input | 8 | Register read data |

## Verification
Read data and the data enable appear one clock edge after the controls are sampled. A RAM commit and the register write pulse land on the edge that first sees the strobe ended. pf_pull_o reacts to pwr_fail_i with no edge in between, and it falls on the RECOV_CYCLES-th edge after release. The bench drives its inputs 1 ns after a rising edge and samples 1 ns after the edge where each result is due. The recovery checks count edges from the release and sample at RECOV_CYCLES-1 edges and at RECOV_CYCLES edges, so an off-by-one in either direction is caught.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int REG_CNT = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              lock_i,
  output acc_e              acc_o,
  output logic              is_reg_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(DEPTH - REG_CNT);

  logic ce_eff_n;
  // lockout forces the chip enable inactive
  assign ce_eff_n = ce_ni | lock_i;
  assign is_reg_o = (addr_i >= REG_BASE);

  always_comb begin
    if (ce_eff_n)   acc_o = ACC_IDLE;
    else if (!we_ni) acc_o = ACC_WRITE;
    else if (!oe_ni) acc_o = ACC_READ;
    else            acc_o = ACC_IDLE;
  end
endmodule

// File: rtl/brc_lockout.sv
module brc_lockout #(
  parameter int RECOV_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_fail_i,
  output logic lock_o
);
  localparam int CNT_W = $clog2(RECOV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (pwr_fail_i)      cnt_q <= CNT_W'(RECOV_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign lock_o = pwr_fail_i | (cnt_q != '0);

  // R7
  fell_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_fail_i) |-> lock_o);
  // R10
  refail_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> lock_o);
  // R7
  no_spurious_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_fail_i && !$past(lock_o)) |-> !lock_o);
endmodule

// File: rtl/brc_wr_commit.sv
module brc_wr_commit #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_now_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [DATA_W-1:0] cap_data_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
    end else begin
      wr_q <= wr_now_i;
      if (wr_now_i) begin
        cap_addr_o <= addr_i;
        cap_data_o <= data_i;
      end
    end
  end

  // strobe end while unlocked commits; a lock-induced end drops the write
  assign commit_o = wr_q & ~wr_now_i & ~lock_i;

  // R9
  lock_kills_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> !wr_q);
endmodule

// File: rtl/brc_ram.sv
module brc_ram #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(DEPTH - REG_CNT);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R6
  ram_range_chk: assert property (@(posedge clk_i)
    we_i |-> (waddr_i < REG_BASE));
endmodule

// File: rtl/bytewide_ram_ctrl.sv
module bytewide_ram_ctrl
  import brc_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int REG_CNT      = 8,
  parameter int RECOV_CYCLES = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       ce_ni,
  input  logic                       oe_ni,
  input  logic                       we_ni,
  input  logic [DATA_W-1:0]          data_i,
  output logic [DATA_W-1:0]          data_o,
  output logic                       data_oe_o,
  input  logic                       pwr_fail_i,
  output logic                       pf_pull_o,
  output logic                       reg_wr_o,
  output logic [$clog2(REG_CNT)-1:0] reg_wr_idx_o,
  output logic [DATA_W-1:0]          reg_wdata_o,
  output logic [$clog2(REG_CNT)-1:0] reg_rd_idx_o,
  input  logic [DATA_W-1:0]          reg_rdata_i
);
  localparam int IDX_W = $clog2(REG_CNT);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(DEPTH - REG_CNT);

  logic              lock;
  acc_e              acc;
  logic              is_reg;
  logic              commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_is_reg;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rd;
  logic              oe_q, sel_reg_q;
  logic [DATA_W-1:0] reg_rd_q;

  brc_lockout #(.RECOV_CYCLES(RECOV_CYCLES)) u_lockout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_fail_i (pwr_fail_i),
    .lock_o     (lock)
  );

  brc_decode #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_decode (
    .addr_i   (addr_i),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .lock_i   (lock),
    .acc_o    (acc),
    .is_reg_o (is_reg)
  );

  brc_wr_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_now_i   (acc == ACC_WRITE),
    .lock_i     (lock),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .commit_o   (commit),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data)
  );

  assign cap_is_reg = (cap_addr >= REG_BASE);
  assign ram_we     = commit & ~cap_is_reg;

  brc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (cap_addr),
    .wdata_i (cap_data),
    .raddr_i (addr_i),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q         <= 1'b0;
      sel_reg_q    <= 1'b0;
      reg_rd_q     <= '0;
      reg_wr_o     <= 1'b0;
      reg_wr_idx_o <= '0;
      reg_wdata_o  <= '0;
    end else begin
      oe_q      <= (acc == ACC_READ);
      sel_reg_q <= is_reg;
      reg_rd_q  <= reg_rdata_i;
      reg_wr_o  <= commit & cap_is_reg;
      if (commit & cap_is_reg) begin
        reg_wr_idx_o <= cap_addr[IDX_W-1:0];
        reg_wdata_o  <= cap_data;
      end
    end
  end

  assign reg_rd_idx_o = addr_i[IDX_W-1:0];
  assign data_oe_o    = oe_q;
  assign data_o       = sel_reg_q ? reg_rd_q : ram_rd;
  assign pf_pull_o    = lock;

  // R8
  locked_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> !data_oe_o);
  // R5
  write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> !data_oe_o);
  // R9
  reg_wr_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !$past(lock));
  // R6
  reg_wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
endmodule

// File: tb/bytewide_ram_ctrl_bench.sv
`timescale 1ns/1ps
module bytewide_ram_ctrl_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  logic        pwr_fail = 1'b0;
  logic        pf_pull;
  logic        reg_wr;
  logic [2:0]  reg_wr_idx, reg_rd_idx;
  logic [7:0]  reg_wdata, reg_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign reg_rdata = 8'hA0 | {5'b0, reg_rd_idx};

  bytewide_ram_ctrl #(.RECOV_CYCLES(N)) u_bytewide_ram_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .ce_ni        (ce_n),
    .oe_ni        (oe_n),
    .we_ni        (we_n),
    .data_i       (din),
    .data_o       (dout),
    .data_oe_o    (doe),
    .pwr_fail_i   (pwr_fail),
    .pf_pull_o    (pf_pull),
    .reg_wr_o     (reg_wr),
    .reg_wr_idx_o (reg_wr_idx),
    .reg_wdata_o  (reg_wdata),
    .reg_rd_idx_o (reg_rd_idx),
    .reg_rdata_i  (reg_rdata)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d, logic oe_val);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_val;
    step();
    chk("R5 no drive in write", doe, 0);
    idle();
    step();
  endtask

  task automatic rd(logic [10:0] a, logic [7:0] exp, string req);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    step();
    chk(req, doe, 1);
    chk(req, dout, exp);
    idle();
    step();
    chk("R2 released after deselect", doe, 0);
  endtask

  task automatic t_reset();
    chk("R1 data_oe", doe, 0);
    chk("R1 pf_pull", pf_pull, 0);
    chk("R1 reg_wr", reg_wr, 0);
  endtask

  task automatic t_rw();
    wr(11'h005, 8'h3C, 1'b1);
    wr(11'h123, 8'hA5, 1'b0);  // R5 write with oe low
    wr(11'h7F7, 8'h81, 1'b1);
    rd(11'h005, 8'h3C, "R3 read 005");
    rd(11'h123, 8'hA5, "R5 write ignores oe");
    rd(11'h7F7, 8'h81, "R6 last ram byte");
  endtask

  task automatic t_oe_high();
    addr = 11'h005; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    step();
    chk("R4 oe high no drive", doe, 0);
    idle();
    step();
  endtask

  task automatic t_deselect();
    addr = 11'h005; din = 8'hFF; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    step();
    chk("R2 deselect no drive", doe, 0);
    step();
    idle();
    step();
    rd(11'h005, 8'h3C, "R2 deselect no write");
  endtask

  task automatic t_last_data();
    addr = 11'h010; din = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    step();
    din = 8'h22;
    step();
    idle();
    step();
    rd(11'h010, 8'h22, "R5 last sampled data");
  endtask

  task automatic t_reg();
    addr = 11'h7FA; din = 8'h5E; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    step();
    chk("R6 no pulse during strobe", reg_wr, 0);
    idle();
    step();
    chk("R6 reg_wr pulse", reg_wr, 1);
    chk("R6 reg_wr_idx", reg_wr_idx, 3'd2);
    chk("R6 reg_wdata", reg_wdata, 8'h5E);
    step();
    chk("R6 single pulse", reg_wr, 0);
    rd(11'h7FD, 8'hA5, "R6 reg read");
    rd(11'h7F7, 8'h81, "R6 ram untouched");
  endtask

  task automatic t_pfail();
    pwr_fail = 1'b1;
    #1;
    chk("R7 immediate pull", pf_pull, 1);
    step();
    addr = 11'h005; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    step();
    chk("R8 read blocked in fail", doe, 0);
    din = 8'h99; we_n = 1'b0;
    step();
    idle();
    step();
    pwr_fail = 1'b0;
    repeat (N-1) step();
    chk("R7 held N-1 edges", pf_pull, 1);
    addr = 11'h005; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    step();
    chk("R7 released at N", pf_pull, 0);
    chk("R8 read blocked in recovery", doe, 0);
    step();
    chk("R8 read after recovery", doe, 1);
    chk("R8 locked write dropped", dout, 8'h3C);
    idle();
    step();
  endtask

  task automatic t_write_pf();
    addr = 11'h123; din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    step();
    pwr_fail = 1'b1;
    step();
    idle();
    pwr_fail = 1'b0;
    repeat (N+1) step();
    rd(11'h123, 8'hA5, "R9 interrupted write dropped");
  endtask

  task automatic t_restart();
    pwr_fail = 1'b1;
    step();
    pwr_fail = 1'b0;
    repeat (N/2) step();
    pwr_fail = 1'b1;
    step();
    pwr_fail = 1'b0;
    repeat (N-1) step();
    chk("R10 restarted interval held", pf_pull, 1);
    step();
    chk("R10 restarted interval ends", pf_pull, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_rw();
    t_oe_high();
    t_deselect();
    t_last_data();
    t_reg();
    t_pfail();
    t_write_pf();
    t_restart();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      summary();
    end
  end
endmodule